// File: doc/BRIEF.md
# Programmable Down-Counting Local Timer

This block is the timer slice of a per-core interrupt controller. Software loads a start value into the initial-count register. The block then counts that value down, one step for every prescaled group of bus clocks. When the count runs out it records an expiry. The current count is always visible on an output, so a register read can return it.

A 3-bit divide code sets the prescaler. Its top bit comes from bit 3 of the divide register and its lower two bits from bits 1:0. Bit 2 of that register has no meaning.

The timer entry of the local vector table holds three things: the vector the request carries, a mask bit, and the periodic bit that picks reload-and-continue over one-shot. Expiries build up in a saturating pending counter. An interrupt request is raised while the counter is non-zero, the controller is software-enabled and the timer entry is unmasked. Each accepted request takes one expiry off the counter.

The block keeps the mask bits of the other five local vector entries. A software-enable input that goes low forces every entry to masked and throws away all pending expiries.

Top module: `local_timer`

## Requirements
- R1: The divide code is {wr_data[3], wr_data[1:0]}, written with select 7. The divisor is 2 to the power ((code + 1) mod 8). Code 111 divides by 1, 000 by 2, 011 by 16, 100 by 32 and 110 by 128. Data bit 2 has no effect.
- R2: Writing the initial count (select 6) loads it into the current count, restarts the prescaler and clears the pending expiries. The request falls after that write edge.
- R3: With a zero initial count the timer does not run and the current count reads 0. This holds even when zero is written while a count is in progress.
- R4: After an initial count N is written with divisor D, the current count falls by one every D clocks. The expiry is recorded N*D clock edges after the write edge.
- R5: In one-shot mode (timer entry bit 17 clear) the count stops at 0 after one expiry, and no further expiry follows.
- R6: In periodic mode (bit 17 set) the count reloads to the initial count on expiry and expires again every N*D clocks.
- R7: irq_req is high only when sw_en is high, the timer entry mask (bit 16) is clear and at least one expiry is pending. irq_vec carries timer entry bits [7:0].
- R8: An edge with irq_req and irq_ack both high removes one pending expiry. An expiry and an acceptance on the same edge leave the pending count unchanged.
- R9: While sw_en is low, all six mask bits read 1 and pending expiries are cleared. An entry written in that state is stored masked, and it stays masked after sw_en returns.
- R10: After reset all six entries are masked, the timer vector and periodic bit are 0, the divide code is 000, the initial and current counts are 0 and irq_req is low.
- R11: Selects 0 to 5 write the six local vector entries, with 0 being the timer entry. Only bits [7:0], 16 and 17 of a timer entry write are kept. Other bits are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_en | input | 1 | Software enable of the controller |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | SEL_W | Register select: 0-5 entries, 6 initial count, 7 divide |
| wr_data | input | DATA_W | Write data |
| irq_ack | input | 1 | Request accepted this cycle |
| irq_req | output | 1 | Timer interrupt request |
| irq_vec | output | VEC_W | Vector carried by the request |
| cur_count | output | DATA_W | Current count for reads |
| lvt_masked | output | NUM_LVT | Mask bit of each local vector entry |

## Verification
Two events can land on one clock edge: a new expiry from the periodic reload, and the acceptance of an earlier expiry. The bench runs a periodic count with no acknowledgement so that one expiry is already pending. It then holds irq_ack high across the next expiry edge. The request must still be high after that edge, and must fall after exactly one more acknowledged edge. Any mistake in the combined increment and decrement shows up as a request that stays up for a cycle too long or drops too early.

// File: rtl/local_timer_pkg.sv
package local_timer_pkg;

   // Bit positions inside a local vector entry write
   localparam int unsigned ENTRY_MASK_BIT   = 16;
   localparam int unsigned ENTRY_PERIOD_BIT = 17;

   // Divide code -> log2 of the divisor, wrapping modulo 8
   function automatic logic [2:0] div_shift(input logic [2:0] code);
      return code + 3'd1;
   endfunction

endpackage

// File: rtl/lt_prescaler.sv
module lt_prescaler #(
   parameter int unsigned PRE_W = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic       restart,
   input  logic [2:0] shift,
   output logic       tick
);
   generate
      if (PRE_W < 7) begin : g_bad_width
         $error("lt_prescaler: PRE_W must hold a divisor of 128");
      end
   endgenerate

   logic [PRE_W-1:0] pre_q;
   logic [PRE_W-1:0] limit;

   always_comb limit = PRE_W'((32'd1 << shift) - 32'd1);

   assign tick = run && !restart && (pre_q >= limit);

   always_ff @(posedge clk) begin
      if (!rst_n)                    pre_q <= '0;
      else if (restart || !run)      pre_q <= '0;
      else if (pre_q >= limit)       pre_q <= '0;
      else                           pre_q <= pre_q + 1'b1;
   end

   // R4: a prescaled step always starts a fresh group of clocks
   assert_tick_rewinds_R4: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> (pre_q == '0));

endmodule

// File: rtl/lt_counter.sv
module lt_counter #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             tick,
   input  logic             periodic,
   output logic [CNT_W-1:0] count,
   output logic             running,
   output logic             expire
);
   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("lt_counter: CNT_W too small");
      end
   endgenerate

   logic [CNT_W-1:0] init_q;
   logic [CNT_W-1:0] cnt_q;

   assign count   = cnt_q;
   assign running = (cnt_q != '0);
   assign expire  = tick && (cnt_q == CNT_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         init_q <= '0;
         cnt_q  <= '0;
      end else if (load) begin
         init_q <= load_val;
         cnt_q  <= load_val;
      end else if (tick) begin
         if (cnt_q == CNT_W'(1)) cnt_q <= periodic ? init_q : '0;
         else                    cnt_q <= cnt_q - 1'b1;
      end
   end

   assert_zero_init_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (init_q == '0) |-> (cnt_q == '0));

   assert_count_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= init_q);

   assert_oneshot_stops_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && !periodic) |=> (cnt_q == '0));

   assert_periodic_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && periodic) |=> (cnt_q == $past(init_q)));

endmodule

// File: rtl/lt_pending.sv
module lt_pending #(
   parameter int unsigned PEND_W = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic inc,
   input  logic dec,
   output logic nonzero
);
   generate
      if (PEND_W < 1) begin : g_bad_width
         $error("lt_pending: PEND_W must be at least 1");
      end
   endgenerate

   logic [PEND_W-1:0] pend_q;

   assign nonzero = (pend_q != '0);

   always_ff @(posedge clk) begin
      if (!rst_n)                         pend_q <= '0;
      else if (clr)                       pend_q <= '0;
      else if (inc && !dec && !(&pend_q)) pend_q <= pend_q + 1'b1;
      else if (dec && !inc && nonzero)    pend_q <= pend_q - 1'b1;
   end

   assert_clear_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (pend_q == '0));

   assert_same_edge_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && dec && !clr) |=> $stable(pend_q));

endmodule

// File: rtl/lt_entries.sv
module lt_entries
   import local_timer_pkg::*;
#(
   parameter int unsigned NUM_LVT = 6,
   parameter int unsigned VEC_W   = 8,
   parameter int unsigned SEL_W   = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sw_en,
   input  logic               wr_en,
   input  logic [SEL_W-1:0]   wr_sel,
   input  logic [VEC_W-1:0]   wr_vec,
   input  logic               wr_mask,
   input  logic               wr_period,
   output logic [VEC_W-1:0]   timer_vec,
   output logic               timer_periodic,
   output logic [NUM_LVT-1:0] masked
);
   generate
      for (genvar i = 0; i < NUM_LVT; i++) begin : g_entry
         logic hit;
         assign hit = wr_en && (wr_sel == SEL_W'(i));

         always_ff @(posedge clk) begin
            if (!rst_n)      masked[i] <= 1'b1;
            else if (!sw_en) masked[i] <= 1'b1;
            else if (hit)    masked[i] <= wr_mask;
         end

         if (i == 0) begin : g_timer
            always_ff @(posedge clk) begin
               if (!rst_n) begin
                  timer_vec      <= '0;
                  timer_periodic <= 1'b0;
               end else if (hit) begin
                  timer_vec      <= wr_vec;
                  timer_periodic <= wr_period;
               end
            end
         end
      end
   endgenerate

   assert_disable_masks_all_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !sw_en |=> (&masked));

endmodule

// File: rtl/local_timer.sv
module local_timer
   import local_timer_pkg::*;
#(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned VEC_W   = 8,
   parameter int unsigned NUM_LVT = 6,
   parameter int unsigned SEL_W   = 4,
   parameter int unsigned PEND_W  = 4,
   parameter int unsigned PRE_W   = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sw_en,
   input  logic               wr_en,
   input  logic [SEL_W-1:0]   wr_sel,
   input  logic [DATA_W-1:0]  wr_data,
   input  logic               irq_ack,
   output logic               irq_req,
   output logic [VEC_W-1:0]   irq_vec,
   output logic [DATA_W-1:0]  cur_count,
   output logic [NUM_LVT-1:0] lvt_masked
);
   localparam int unsigned SEL_INIT = NUM_LVT;
   localparam int unsigned SEL_DIV  = NUM_LVT + 1;

   generate
      if (SEL_DIV >= (1 << SEL_W)) begin : g_bad_sel
         $error("local_timer: SEL_W too narrow for the register set");
      end
      if (DATA_W <= ENTRY_PERIOD_BIT) begin : g_bad_data
         $error("local_timer: DATA_W must cover the entry fields");
      end
      if (VEC_W > ENTRY_MASK_BIT) begin : g_bad_vec
         $error("local_timer: vector overlaps the mask bit");
      end
   endgenerate

   logic       load;
   logic [2:0] div_code_q;
   logic       tick, running, expire, pend_nz, periodic;

   assign load = wr_en && (wr_sel == SEL_W'(SEL_INIT));

   always_ff @(posedge clk) begin
      if (!rst_n) div_code_q <= 3'b000;
      else if (wr_en && (wr_sel == SEL_W'(SEL_DIV)))
         div_code_q <= {wr_data[3], wr_data[1:0]};
   end

   lt_entries #(.NUM_LVT(NUM_LVT), .VEC_W(VEC_W), .SEL_W(SEL_W)) u_entries (
      .clk(clk), .rst_n(rst_n), .sw_en(sw_en),
      .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_vec(wr_data[VEC_W-1:0]),
      .wr_mask(wr_data[ENTRY_MASK_BIT]),
      .wr_period(wr_data[ENTRY_PERIOD_BIT]),
      .timer_vec(irq_vec), .timer_periodic(periodic), .masked(lvt_masked));

   lt_prescaler #(.PRE_W(PRE_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .run(running), .restart(load),
      .shift(div_shift(div_code_q)), .tick(tick));

   lt_counter #(.CNT_W(DATA_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .load(load), .load_val(wr_data),
      .tick(tick), .periodic(periodic),
      .count(cur_count), .running(running), .expire(expire));

   lt_pending #(.PEND_W(PEND_W)) u_pend (
      .clk(clk), .rst_n(rst_n),
      .clr(!sw_en || load), .inc(expire), .dec(irq_req && irq_ack),
      .nonzero(pend_nz));

   assign irq_req = sw_en && !lvt_masked[0] && pend_nz;

   assert_load_drops_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> !irq_req);

   assert_req_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (sw_en && !lvt_masked[0]));

endmodule

// File: tb/local_timer_test.sv
module local_timer_test;
   localparam time CLK_PERIOD = 10ns;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sw_en = 1'b1;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_sel = '0;
   logic [31:0] wr_data = '0;
   logic        irq_ack = 1'b0;
   logic        irq_req;
   logic [7:0]  irq_vec;
   logic [31:0] cur_count;
   logic [5:0]  lvt_masked;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   local_timer uut (
      .clk(clk), .rst_n(rst_n), .sw_en(sw_en), .wr_en(wr_en),
      .wr_sel(wr_sel), .wr_data(wr_data), .irq_ack(irq_ack),
      .irq_req(irq_req), .irq_vec(irq_vec), .cur_count(cur_count),
      .lvt_masked(lvt_masked));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] sel, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic waitn(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic accept();
      irq_ack = 1'b1;
      @(negedge clk);
      irq_ack = 1'b0;
   endtask

   task automatic t_reset();
      chk("R10 count", cur_count, 32'd0);
      chk("R10 masks", {26'd0, lvt_masked}, 32'h3F);
      chk("R10 req", {31'd0, irq_req}, 32'd0);
      chk("R10 vec", {24'd0, irq_vec}, 32'd0);
   endtask

   task automatic t_oneshot();
      wr(4'd0, 32'h0000_0041);
      wr(4'd7, 32'h0);             // code 000 -> divide by 2
      wr(4'd6, 32'd3);
      waitn(2);
      chk("R4 step", cur_count, 32'd2);
      waitn(3);
      chk("R4 no early expiry", {31'd0, irq_req}, 32'd0);
      chk("R4 count 1", cur_count, 32'd1);
      waitn(1);
      chk("R4 expiry", {31'd0, irq_req}, 32'd1);
      chk("R7 vec", {24'd0, irq_vec}, 32'h41);
      chk("R5 stopped", cur_count, 32'd0);
      accept();
      chk("R8 accepted", {31'd0, irq_req}, 32'd0);
      waitn(20);
      chk("R5 single expiry", {31'd0, irq_req}, 32'd0);
      chk("R5 stays 0", cur_count, 32'd0);
   endtask

   task automatic div_case(input logic [31:0] d, input int n, input int div, input string tag);
      wr(4'd7, d);
      wr(4'd6, n);
      chk({tag, " R2 cleared"}, {31'd0, irq_req}, 32'd0);
      waitn(n*div - 1);
      chk({tag, " R1 early"}, {31'd0, irq_req}, 32'd0);
      chk({tag, " R1 count"}, cur_count, 32'd1);
      waitn(1);
      chk({tag, " R1 expiry"}, {31'd0, irq_req}, 32'd1);
   endtask

   task automatic t_divide();
      div_case(32'hB, 5, 1, "code111");
      div_case(32'h3, 2, 16, "code011");
      div_case(32'h8, 1, 32, "code100");
      div_case(32'h4, 2, 2, "bit2");
      div_case(32'hA, 1, 128, "code110");
   endtask

   task automatic t_periodic();
      wr(4'd0, 32'h0002_0022);
      wr(4'd7, 32'hB);
      wr(4'd6, 32'd4);
      waitn(4);
      chk("R6 first expiry", {31'd0, irq_req}, 32'd1);
      chk("R6 reload", cur_count, 32'd4);
      waitn(3);
      irq_ack = 1'b1;              // held across the second expiry edge
      waitn(1);
      chk("R8 same edge", {31'd0, irq_req}, 32'd1);
      waitn(1);
      irq_ack = 1'b0;
      chk("R8 drained", {31'd0, irq_req}, 32'd0);
      chk("R6 counting", cur_count, 32'd3);
      waitn(3);
      chk("R6 third expiry", {31'd0, irq_req}, 32'd1);
   endtask

   task automatic t_zero();
      wr(4'd7, 32'hB);
      wr(4'd6, 32'd100);
      waitn(10);
      chk("R4 running", cur_count, 32'd90);
      wr(4'd6, 32'd0);
      chk("R3 cancel", cur_count, 32'd0);
      waitn(50);
      chk("R3 idle", cur_count, 32'd0);
      chk("R3 no req", {31'd0, irq_req}, 32'd0);
   endtask

   task automatic t_mask();
      wr(4'd0, 32'h0001_0055);
      wr(4'd7, 32'hB);
      wr(4'd6, 32'd2);
      waitn(2);
      chk("R7 masked", {31'd0, irq_req}, 32'd0);
      wr(4'd0, 32'h0000_0055);
      chk("R7 unmasked", {31'd0, irq_req}, 32'd1);
      chk("R7 vec", {24'd0, irq_vec}, 32'h55);
      accept();
      wr(4'd0, 32'hFFFC_FF33);
      wr(4'd6, 32'd1);
      waitn(1);
      chk("R11 req", {31'd0, irq_req}, 32'd1);
      chk("R11 vec", {24'd0, irq_vec}, 32'h33);
      chk("R11 mask", {31'd0, lvt_masked[0]}, 32'd0);
      accept();
      waitn(5);
      chk("R11 oneshot", {31'd0, irq_req}, 32'd0);
   endtask

   task automatic t_disable();
      for (int i = 0; i < 6; i++) wr(4'(i), 32'h10);
      chk("R11 entries", {26'd0, lvt_masked}, 32'd0);
      wr(4'd7, 32'hB);
      wr(4'd6, 32'd1);
      waitn(1);
      chk("R9 pre", {31'd0, irq_req}, 32'd1);
      sw_en = 1'b0;
      waitn(1);
      chk("R9 all masked", {26'd0, lvt_masked}, 32'h3F);
      chk("R9 no req", {31'd0, irq_req}, 32'd0);
      wr(4'd2, 32'h10);
      chk("R9 stored masked", {26'd0, lvt_masked}, 32'h3F);
      sw_en = 1'b1;
      waitn(1);
      chk("R9 after enable", {26'd0, lvt_masked}, 32'h3F);
      wr(4'd0, 32'h10);
      chk("R9 unmask timer", {26'd0, lvt_masked}, 32'h3E);
      chk("R9 pending gone", {31'd0, irq_req}, 32'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_oneshot();
      t_divide();
      t_periodic();
      t_zero();
      t_mask();
      t_disable();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule